// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Window

This block is the eight-byte register window that host software uses to control one bus-master disk DMA channel. It stores a command byte (run control and transfer direction), a status byte (engine activity, error and interrupt flags plus two per-drive capability flags), two plain scratch bytes and a 32-bit pointer to the descriptor table. Software reaches it over a small register bus that accepts single-byte accesses at any offset or 32-bit accesses at offsets 0 and 4.

A separate DMA engine, which is not part of this block, receives a run qualifier and the direction. It reports back with single-cycle done, error and interrupt pulses. The block holds those events in the status byte until software clears them. It also drives a level interrupt line to the host. Reads return data combinationally from the current register state. Writes take effect at the next clock edge.

Top module: `bm_dma_regs`

## Requirements
- R1: The window has eight byte lanes. Offset 0 is the command byte, offsets 1 and 3 are read/write scratch bytes, offset 2 is the status byte, and offsets 4 to 7 hold the descriptor pointer in little-endian order. A 32-bit access at offset 0 or 4 covers four lanes, with lane n on data bits 8n+7:8n. A byte access at any offset uses data bits 7:0 and reads zero in bits 31:8.
- R2: Command bit 0 is the run bit. When a write changes it from 0 to 1 while the pointer is nonzero, status bit 0 (active) reads 1 after that write. A write that leaves bit 0 at 0 clears both run and active. Output `dmaGo` is high when both run and active are set.
- R3: Command bit 3 is the direction bit, where 1 means drive to memory. It appears on `dmaToMem`. A write that arrives while the run bit is already 1 leaves the direction bit unchanged. All other command bits read 0.
- R4: In the status byte, bit 0 is active, bit 1 is error and bit 2 is interrupt. Bits 3, 4 and 7 always read 0.
- R5: Writing 1 to status bit 1 or bit 2 clears that flag. Writing 0 to either bit leaves it unchanged.
- R6: Status bits 5 and 6 are read/write capability flags for drive 0 and drive 1. Every status write loads them.
- R7: An `engDone` pulse clears active. An `engErr` pulse sets error and clears active. An `engIrq` pulse sets interrupt. After `engDone` and `engIrq` pulse together, the low three status bits read 100b.
- R8: When an engine event and a clearing write to the same status flag arrive in the same cycle, the flag ends up set.
- R9: `irqOut` equals status bit 2 at all times.
- R10: Writes to pointer bits 1:0 are discarded, and those bits read 0.
- R11: After reset, every register reads 0 and `dmaGo`, `dmaToMem` and `irqOut` are low.
- R12: Setting the run bit while the pointer is zero sets the run bit but leaves active at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Byte offset within the window |
| busWr | input | 1 | Write strobe |
| busDword | input | 1 | 1 selects a 32-bit access, 0 a byte access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| engDone | input | 1 | Engine transfer-complete pulse |
| engErr | input | 1 | Engine error pulse |
| engIrq | input | 1 | Drive interrupt pulse |
| dmaGo | output | 1 | Run qualifier to the engine |
| dmaToMem | output | 1 | Direction to the engine (1 = drive to memory) |
| irqOut | output | 1 | Level interrupt to the host |

## Verification
Two operations can target the same flag in a single cycle. One is a software write that clears the error or interrupt flag. The other is an engine pulse that sets that same flag. The bench produces this collision by raising `engErr`, and separately `engIrq`, on the same clock edge as a status write with the matching clear bit set. Reading the status byte afterwards must show the flag still set, because an engine event may never be lost. A later write with no engine pulse then shows that the clear itself works.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int WIN_BYTES = 8;
  localparam int DRIVES    = 2;
  localparam int PTR_BYTES = 4;

  localparam int CMD_OFS  = 0;
  localparam int STAT_OFS = 2;
  localparam int PTR_OFS  = 4;

  localparam int CMD_RUN   = 0;
  localparam int CMD_TOMEM = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_INT    = 2;
  localparam int ST_CAP0   = 5;

  typedef struct packed {
    logic              cmdWr;
    logic              cmdRun;
    logic              cmdToMem;
    logic              statWr;
    logic              statClrErr;
    logic              statClrInt;
    logic [DRIVES-1:0] statCap;
  } regStrobe_t;
endpackage

// File: rtl/bmdma_dpath.sv
module bmdma_dpath
  import bmdma_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [$clog2(WIN_BYTES)-1:0] busAddr,
  input  logic                         busWr,
  input  logic                         busDword,
  input  logic [BUS_W-1:0]             busWdata,
  input  logic [7:0]                   cmdByte,
  input  logic [7:0]                   statByte,
  output regStrobe_t                   strobe,
  output logic                         prdValid,
  output logic [BUS_W-1:0]             busRdata
);
  localparam int AW       = $clog2(WIN_BYTES);
  localparam int LANE_CNT = BUS_W / 8;
  localparam int LW       = $clog2(LANE_CNT);

  logic [WIN_BYTES-1:0] laneWe;
  logic [7:0]           laneData [WIN_BYTES];
  logic [7:0]           view     [WIN_BYTES];

  for (genvar i = 0; i < WIN_BYTES; i++) begin : g_lane
    logic hit;
    assign hit = busDword ? ((busAddr >> LW) == (AW'(i) >> LW)) : (busAddr == AW'(i));
    assign laneWe[i]   = busWr & hit;
    assign laneData[i] = busDword ? busWdata[8*(i%LANE_CNT) +: 8] : busWdata[7:0];

    if (i == CMD_OFS) begin : g_cmd
      assign view[i] = cmdByte;
    end else if (i == STAT_OFS) begin : g_stat
      assign view[i] = statByte;
    end else begin : g_store
      localparam logic [7:0] KEEP = (i == PTR_OFS) ? 8'hFC : 8'hFF;
      logic [7:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          q <= '0;
        else if (laneWe[i]) q <= laneData[i] & KEEP;
      end
      assign view[i] = q;
    end
  end

  // strobes handed to the control side
  always_comb begin
    strobe            = '0;
    strobe.cmdWr      = laneWe[CMD_OFS];
    strobe.cmdRun     = laneData[CMD_OFS][CMD_RUN];
    strobe.cmdToMem   = laneData[CMD_OFS][CMD_TOMEM];
    strobe.statWr     = laneWe[STAT_OFS];
    strobe.statClrErr = laneData[STAT_OFS][ST_ERR];
    strobe.statClrInt = laneData[STAT_OFS][ST_INT];
    for (int d = 0; d < DRIVES; d++) strobe.statCap[d] = laneData[STAT_OFS][ST_CAP0+d];
  end

  always_comb begin
    prdValid = 1'b0;
    for (int j = 0; j < PTR_BYTES; j++) prdValid = prdValid | (view[PTR_OFS+j] != 8'h00);
  end

  always_comb begin
    busRdata = '0;
    if (busDword) begin
      for (int k = 0; k < LANE_CNT; k++)
        busRdata[8*k +: 8] = view[AW'(int'(busAddr >> LW) * LANE_CNT + k)];
    end else begin
      busRdata[7:0] = view[busAddr];
    end
  end

  // R10: low pointer bits never hold a written value
  assert_ptr_lowbits_R10: assert property (@(posedge clk) disable iff (!rstN)
    laneWe[PTR_OFS] |=> (view[PTR_OFS][1:0] == 2'b00));

  // R1: a byte read never returns data above bit 7
  assert_byte_read_width_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busDword |-> (busRdata[BUS_W-1:8] == '0));
endmodule

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  regStrobe_t strobe,
  input  logic       prdValid,
  input  logic       engDone,
  input  logic       engErr,
  input  logic       engIrq,
  output logic [7:0] cmdByte,
  output logic [7:0] statByte,
  output logic       dmaGo,
  output logic       dmaToMem,
  output logic       irqOut
);
  logic              runQ, toMemQ, actQ, errQ, intQ;
  logic [DRIVES-1:0] capQ;
  logic              runRise, stopWr;

  assign runRise = strobe.cmdWr &  strobe.cmdRun & ~runQ;
  assign stopWr  = strobe.cmdWr & ~strobe.cmdRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      toMemQ <= 1'b0;
    end else if (strobe.cmdWr) begin
      runQ <= strobe.cmdRun;
      if (!runQ) toMemQ <= strobe.cmdToMem;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     actQ <= 1'b0;
    else if (stopWr)               actQ <= 1'b0;
    else if (runRise && prdValid)  actQ <= 1'b1;
    else if (engDone || engErr)    actQ <= 1'b0;
  end

  // engine events take priority over software clears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ <= 1'b0;
      intQ <= 1'b0;
    end else begin
      if (engErr)                                  errQ <= 1'b1;
      else if (strobe.statWr && strobe.statClrErr) errQ <= 1'b0;
      if (engIrq)                                  intQ <= 1'b1;
      else if (strobe.statWr && strobe.statClrInt) intQ <= 1'b0;
    end
  end

  for (genvar d = 0; d < DRIVES; d++) begin : g_cap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              capQ[d] <= 1'b0;
      else if (strobe.statWr) capQ[d] <= strobe.statCap[d];
    end
  end

  always_comb begin
    statByte         = '0;
    statByte[ST_ACT] = actQ;
    statByte[ST_ERR] = errQ;
    statByte[ST_INT] = intQ;
    for (int d = 0; d < DRIVES; d++) statByte[ST_CAP0+d] = capQ[d];
    cmdByte            = '0;
    cmdByte[CMD_RUN]   = runQ;
    cmdByte[CMD_TOMEM] = toMemQ;
  end

  assign dmaGo    = runQ & actQ;
  assign dmaToMem = toMemQ;
  assign irqOut   = intQ;

  assert_act_needs_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    actQ |-> runQ);
  assert_stop_clears_act_R2: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> !actQ);
  assert_dir_locked_R3: assert property (@(posedge clk) disable iff (!rstN)
    runQ |=> $stable(toMemQ));
  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (engDone && !runRise) |=> !actQ);
  assert_err_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    engErr |=> errQ);
  assert_int_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    engIrq |=> intQ);
  assert_null_ptr_R12: assert property (@(posedge clk) disable iff (!rstN)
    (runRise && !prdValid && !actQ) |=> !actQ);
endmodule

// File: rtl/bm_dma_regs.sv
module bm_dma_regs
  import bmdma_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [$clog2(WIN_BYTES)-1:0] busAddr,
  input  logic                         busWr,
  input  logic                         busDword,
  input  logic [BUS_W-1:0]             busWdata,
  output logic [BUS_W-1:0]             busRdata,
  input  logic                         engDone,
  input  logic                         engErr,
  input  logic                         engIrq,
  output logic                         dmaGo,
  output logic                         dmaToMem,
  output logic                         irqOut
);
  regStrobe_t strobe;
  logic [7:0] cmdByte, statByte;
  logic       prdValid;

  bmdma_dpath #(.BUS_W(BUS_W)) u_dpath (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busDword(busDword), .busWdata(busWdata), .cmdByte(cmdByte),
    .statByte(statByte), .strobe(strobe), .prdValid(prdValid),
    .busRdata(busRdata)
  );

  bmdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .prdValid(prdValid),
    .engDone(engDone), .engErr(engErr), .engIrq(engIrq),
    .cmdByte(cmdByte), .statByte(statByte), .dmaGo(dmaGo),
    .dmaToMem(dmaToMem), .irqOut(irqOut)
  );

  // R9: the interrupt line tracks the status flag as read over the bus
  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == statByte[ST_INT]);
endmodule

// File: tb/bm_dma_regs_tb.sv
module bm_dma_regs_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWr = 1'b0, busDword = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        engDone = 1'b0, engErr = 1'b0, engIrq = 1'b0;
  logic        dmaGo, dmaToMem, irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bm_dma_regs u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busDword(busDword), .busWdata(busWdata), .busRdata(busRdata),
    .engDone(engDone), .engErr(engErr), .engIrq(engIrq),
    .dmaGo(dmaGo), .dmaToMem(dmaToMem), .irqOut(irqOut)
  );

  typedef struct packed {
    logic        wr;
    logic        dw;
    logic [2:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 3'd0, 32'h0,        32'h0,        4'd11}, // R11 reset
    '{1'b0, 1'b1, 3'd4, 32'h0,        32'h0,        4'd11}, // R11
    '{1'b1, 1'b1, 3'd4, 32'h12345677, 32'h0,        4'd10}, // R10
    '{1'b0, 1'b1, 3'd4, 32'h0,        32'h12345674, 4'd10}, // R10
    '{1'b0, 1'b0, 3'd7, 32'h0,        32'h00000012, 4'd1},  // R1
    '{1'b0, 1'b0, 3'd4, 32'h0,        32'h00000074, 4'd10}, // R10
    '{1'b1, 1'b0, 3'd1, 32'h000000A5, 32'h0,        4'd1},  // R1
    '{1'b1, 1'b0, 3'd3, 32'h0000005A, 32'h0,        4'd1},  // R1
    '{1'b0, 1'b1, 3'd0, 32'h0,        32'h5A00A500, 4'd1},  // R1
    '{1'b1, 1'b0, 3'd2, 32'h00000060, 32'h0,        4'd6},  // R6
    '{1'b0, 1'b0, 3'd2, 32'h0,        32'h00000060, 4'd6},  // R6
    '{1'b1, 1'b0, 3'd2, 32'h00000020, 32'h0,        4'd6},  // R6
    '{1'b0, 1'b0, 3'd2, 32'h0,        32'h00000020, 4'd6},  // R6
    '{1'b1, 1'b0, 3'd0, 32'h00000009, 32'h0,        4'd2},  // R2
    '{1'b0, 1'b0, 3'd0, 32'h0,        32'h00000009, 4'd3},  // R3
    '{1'b0, 1'b0, 3'd2, 32'h0,        32'h00000021, 4'd2},  // R2
    '{1'b1, 1'b0, 3'd0, 32'h00000001, 32'h0,        4'd3},  // R3
    '{1'b0, 1'b0, 3'd0, 32'h0,        32'h00000009, 4'd3},  // R3
    '{1'b1, 1'b0, 3'd0, 32'h00000000, 32'h0,        4'd2},  // R2
    '{1'b0, 1'b0, 3'd2, 32'h0,        32'h00000020, 4'd2},  // R2
    '{1'b0, 1'b0, 3'd0, 32'h0,        32'h00000008, 4'd3},  // R3
    '{1'b1, 1'b0, 3'd0, 32'h00000000, 32'h0,        4'd3},  // R3
    '{1'b0, 1'b0, 3'd0, 32'h0,        32'h00000000, 4'd3},  // R3
    '{1'b1, 1'b0, 3'd2, 32'h000000B8, 32'h0,        4'd4},  // R4
    '{1'b0, 1'b0, 3'd2, 32'h0,        32'h00000020, 4'd4}   // R4
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic dw, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busDword = dw; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic dw, output logic [31:0] q);
    @(negedge clk);
    busAddr = a; busDword = dw; busWr = 1'b0;
    #1 q = busRdata;
  endtask

  // engine pulse, optionally together with a byte write
  task automatic ev(input logic d, input logic e, input logic i,
                    input logic w, input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    engDone = d; engErr = e; engIrq = i;
    busWr = w; busAddr = a; busDword = 1'b0; busWdata = v;
    @(negedge clk);
    engDone = 1'b0; engErr = 1'b0; engIrq = 1'b0; busWr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 outputs", {29'b0, dmaGo, dmaToMem, irqOut}, 32'h0);

    for (int n = 0; n < NV; n++) begin
      if (VEC[n].wr) wr(VEC[n].a, VEC[n].dw, VEC[n].d);
      else begin
        rd(VEC[n].a, VEC[n].dw, q);
        chk($sformatf("R%0d vec%0d", VEC[n].req, n), q, VEC[n].exp);
      end
    end

    // run with a valid pointer
    wr(3'd0, 1'b0, 32'h01);
    rd(3'd2, 1'b0, q);
    chk("R2 active", q, 32'h21);
    chk("R2 dmaGo", {31'b0, dmaGo}, 32'h1);
    chk("R3 dir out", {31'b0, dmaToMem}, 32'h0);

    // successful completion
    ev(1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
    rd(3'd2, 1'b0, q);
    chk("R7 success code", {29'b0, q[2:0]}, 32'h4);
    chk("R9 irq high", {31'b0, irqOut}, 32'h1);
    chk("R7 dmaGo off", {31'b0, dmaGo}, 32'h0);

    wr(3'd2, 1'b0, 32'h20);
    rd(3'd2, 1'b0, q);
    chk("R5 zero write keeps", q, 32'h24);
    wr(3'd2, 1'b0, 32'h26);
    rd(3'd2, 1'b0, q);
    chk("R5 w1c", q, 32'h20);
    chk("R9 irq low", {31'b0, irqOut}, 32'h0);

    // error path
    wr(3'd0, 1'b0, 32'h00);
    wr(3'd0, 1'b0, 32'h01);
    ev(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0);
    rd(3'd2, 1'b0, q);
    chk("R7 error", q, 32'h22);

    // R8 collisions: set beats clear
    ev(1'b0, 1'b1, 1'b0, 1'b1, 3'd2, 32'h22);
    rd(3'd2, 1'b0, q);
    chk("R8 err collision", q, 32'h22);
    ev(1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 32'h26);
    rd(3'd2, 1'b0, q);
    chk("R8 int collision", q, 32'h24);
    wr(3'd2, 1'b0, 32'h26);
    rd(3'd2, 1'b0, q);
    chk("R5 final clear", q, 32'h20);

    // R12: zero pointer
    wr(3'd0, 1'b0, 32'h00);
    wr(3'd4, 1'b1, 32'h00000003);
    rd(3'd4, 1'b1, q);
    chk("R10 ptr zero", q, 32'h0);
    wr(3'd0, 1'b0, 32'h01);
    rd(3'd2, 1'b0, q);
    chk("R12 no active", q, 32'h20);
    rd(3'd0, 1'b0, q);
    chk("R12 run set", q, 32'h01);
    chk("R12 dmaGo", {31'b0, dmaGo}, 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule